// File: doc/BRIEF.md
# Eight-Channel Down-Counter Timer Bank

The block holds eight independent 32-bit down-counters behind a word-wide register port. Each channel keeps a live count, a reload value and two match words. A single control word gives every channel a 4-bit field that selects enable, clock source, expiry interrupt and pulse mode. An enabled channel counts down once per selected tick. When it reaches zero it expires, and on the following tick it reloads, so it runs periodically with a period of reload+1 ticks.

The clock source is either every cycle of the bus clock or a slower external tick. The external tick arrives as a one-cycle enable input that is synchronous to the bus clock. Each channel drives its own interrupt line, and that line inverts its level on each qualifying expiry, so software must treat both edges as events. A secondary control word is stored and can be read back, but it changes nothing. Pulse-waveform output is not built. The pulse bit is stored only on channels that support it, and an attempt to set it on any other channel raises a one-cycle error strobe.

Top module: `tmr_bank`

## Requirements
- R1: The register map uses byte addresses, 16 bytes per channel. Channels 0..2 sit at blocks 0x00, 0x10 and 0x20, and channels 3..7 at 0x40..0x80. Within a block the words are count (+0), reload (+4), match A (+8) and match B (+0xC). The control word is at 0x30 and the secondary control word at 0x34. A read registers its data on the clock edge that accepts the request.
- R2: An access to 0x38, to 0x3C, to any block above channel 7 or to a non-word-aligned address is illegal. An illegal read returns zero and an illegal write changes no state.
- R3: The control field of channel c is bits [4c+3:4c]. Bit 0 is enable, bit 1 selects the external tick (0 selects the bus clock), bit 2 enables the expiry interrupt and bit 3 is pulse mode. An enabled channel decrements on every bus cycle when bit 1 is 0, and only on cycles where ext_tick_i is high when bit 1 is 1.
- R4: On a tick where the count is 1, the count becomes 0 and the channel expires. On the next tick the count reloads from the reload word, so the period is reload+1 ticks.
- R5: On an expiry the interrupt line inverts if either the expiry interrupt bit is set or one of the two match words is zero. Otherwise the line keeps its level.
- R6: A disabled channel does not count and ignores writes to its count word. A reload write to a disabled channel also loads the count.
- R7: A control write that clears a channel's enable bit stops the channel and loads its count from the reload word in the same edge. The interrupt level is kept.
- R8: A single control write applies all field changes together on the next edge. Enabling a channel and switching it to the external tick in one write therefore takes no bus-clock tick.
- R9: Pulse bits of channels 0..3 always read as zero. A control write that sets one of them pulses pulse_err_o high for exactly one cycle after the write. Pulse bits of channels 4..7 are stored and raise no error.
- R10: After reset every count, reload, match and control word is zero, every interrupt line is low and all channels are disabled and clocked by the bus clock.
- R11: A count write to an enabled channel loads the written value and takes precedence over a tick in the same cycle.
- R12: The secondary control word stores any value and reads it back, and it has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_tick_i | input | 1 | One-cycle external tick enable |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 8 | Per-channel toggling interrupt levels |
| pulse_err_o | output | 1 | Strobe for a pulse request on an unsupported channel |

## Verification
Every result is registered, so each appears one edge after its stimulus. Read data, new control fields, count reloads on disable and the error strobe are valid at the first falling edge after the accepting rising edge, and the bench samples there. A bus-clock channel enabled at edge E first decrements at E+1, so back-to-back reads return the starting count and then one less. To make count checks cycle-exact, the bench runs channels on the external tick and raises it for exactly one rising edge at a time. After each tick it compares all eight interrupt levels with an arithmetic model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int FLD_W     = 4;
  localparam int FLD_EN    = 0;
  localparam int FLD_EXT   = 1;
  localparam int FLD_IE    = 2;
  localparam int FLD_PULSE = 3;

  typedef enum logic [1:0] {
    W_CNT = 2'd0,
    W_RLD = 2'd1,
    W_MA  = 2'd2,
    W_MB  = 2'd3
  } word_e;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
  parameter int N_CH  = 8,
  parameter int LO_CH = 3,
  parameter int AW    = 8,
  parameter int CW    = 3
) (
  input  logic [AW-1:0] addr_i,
  output logic          sel_ctrl_o,
  output logic          sel_ctrl2_o,
  output logic          sel_ch_o,
  output logic [CW-1:0] ch_o,
  output logic [1:0]    word_o
);
  int blk;
  int chi;

  always_comb begin
    blk         = int'(addr_i[AW-1:4]);
    chi         = 0;
    sel_ctrl_o  = 1'b0;
    sel_ctrl2_o = 1'b0;
    sel_ch_o    = 1'b0;
    if (addr_i[1:0] == 2'b00) begin
      if (blk == LO_CH) begin
        sel_ctrl_o  = (addr_i[3:2] == 2'd0);
        sel_ctrl2_o = (addr_i[3:2] == 2'd1);
      end else if (blk < LO_CH) begin
        sel_ch_o = 1'b1;
        chi      = blk;
      end else if (blk - 1 < N_CH) begin
        sel_ch_o = 1'b1;
        chi      = blk - 1;
      end
    end
    ch_o   = CW'(chi);
    word_o = addr_i[3:2];
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ext_sel_i,
  input  logic          ovf_ie_i,
  input  logic          ext_tick_i,
  input  logic          dis_i,
  input  logic          cnt_we_i,
  input  logic          rld_we_i,
  input  logic          ma_we_i,
  input  logic          mb_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic [DW-1:0] ma_o,
  output logic [DW-1:0] mb_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt_q, rld_q, ma_q, mb_q;
  logic          irq_q;
  logic          tick, expire, match_hit;

  assign tick      = en_i && (!ext_sel_i || ext_tick_i);
  assign expire    = tick && !dis_i && !cnt_we_i && (cnt_q == DW'(1));
  assign match_hit = (ma_q == '0) || (mb_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      ma_q  <= '0;
      mb_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      // disable wins, then software loads, then the tick
      if (dis_i)                   cnt_q <= rld_q;
      else if (cnt_we_i && en_i)   cnt_q <= wdata_i;
      else if (rld_we_i && !en_i)  cnt_q <= wdata_i;
      else if (tick)               cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - DW'(1);
      if (rld_we_i) rld_q <= wdata_i;
      if (ma_we_i)  ma_q  <= wdata_i;
      if (mb_we_i)  mb_q  <= wdata_i;
      if (expire && (ovf_ie_i || match_hit)) irq_q <= ~irq_q;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ma_o  = ma_q;
  assign mb_o  = mb_q;
  assign irq_o = irq_q;

  // R5: a level change only follows a 1 -> 0 count step
  a_r5_irq_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_q) |-> ($past(cnt_q) == DW'(1) && cnt_q == '0));

  // R6: idle channel keeps its count unless reload is written
  a_r6_frozen_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !rld_we_i) |=> $stable(cnt_q));

  // R7: disable reloads
  a_r7_disable_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (cnt_q == $past(rld_q)));

  // R4: tick at zero reloads
  a_r4_reload_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q == '0 && !dis_i && !cnt_we_i) |=> (cnt_q == $past(rld_q)));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int DW          = 32,
  parameter int AW          = 8,
  parameter int LO_CH       = 3,
  parameter int PULSE_FIRST = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_tick_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] irq_o,
  output logic            pulse_err_o
);
  localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int CTW = N_CH * FLD_W;

  logic          sel_ctrl, sel_ctrl2, sel_ch, legal, wr, rd, ctrl_wr;
  logic [CW-1:0] ch_idx;
  logic [1:0]    word;

  logic [CTW-1:0]  ctrl_q, ctrl_nxt;
  logic [DW-1:0]   ctrl2_q, rd_val, rdata_q;
  logic [N_CH-1:0] dis, perr;
  logic            pulse_err_q;
  logic [DW-1:0]   cnt_a [N_CH];
  logic [DW-1:0]   rld_a [N_CH];
  logic [DW-1:0]   ma_a  [N_CH];
  logic [DW-1:0]   mb_a  [N_CH];

  tmr_regdec #(.N_CH(N_CH), .LO_CH(LO_CH), .AW(AW), .CW(CW)) u_dec (
    .addr_i      (addr_i),
    .sel_ctrl_o  (sel_ctrl),
    .sel_ctrl2_o (sel_ctrl2),
    .sel_ch_o    (sel_ch),
    .ch_o        (ch_idx),
    .word_o      (word)
  );

  assign legal   = sel_ctrl || sel_ctrl2 || sel_ch;
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign ctrl_wr = wr && sel_ctrl;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int B = c * FLD_W;
    logic hit;
    assign hit = wr && sel_ch && (ch_idx == CW'(c));

    if (c < PULSE_FIRST) begin : g_nopulse
      assign ctrl_nxt[B +: FLD_W] = {1'b0, wdata_i[B +: FLD_W-1]};
      assign perr[c] = ctrl_wr && wdata_i[B + FLD_PULSE];
    end else begin : g_pulse
      assign ctrl_nxt[B +: FLD_W] = wdata_i[B +: FLD_W];
      assign perr[c] = 1'b0;
    end

    // clearing enable: stop and reload ahead of other field changes
    assign dis[c] = ctrl_wr && ctrl_q[B + FLD_EN] && !wdata_i[B + FLD_EN];

    tmr_chan #(.DW(DW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ctrl_q[B + FLD_EN]),
      .ext_sel_i  (ctrl_q[B + FLD_EXT]),
      .ovf_ie_i   (ctrl_q[B + FLD_IE]),
      .ext_tick_i (ext_tick_i),
      .dis_i      (dis[c]),
      .cnt_we_i   (hit && word == W_CNT),
      .rld_we_i   (hit && word == W_RLD),
      .ma_we_i    (hit && word == W_MA),
      .mb_we_i    (hit && word == W_MB),
      .wdata_i    (wdata_i),
      .cnt_o      (cnt_a[c]),
      .rld_o      (rld_a[c]),
      .ma_o       (ma_a[c]),
      .mb_o       (mb_a[c]),
      .irq_o      (irq_o[c])
    );
  end

  always_comb begin
    rd_val = '0;
    if (sel_ctrl)       rd_val = DW'(ctrl_q);
    else if (sel_ctrl2) rd_val = ctrl2_q;
    else if (sel_ch) begin
      case (word)
        W_CNT:   rd_val = cnt_a[ch_idx];
        W_RLD:   rd_val = rld_a[ch_idx];
        W_MA:    rd_val = ma_a[ch_idx];
        default: rd_val = mb_a[ch_idx];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      ctrl2_q     <= '0;
      rdata_q     <= '0;
      pulse_err_q <= 1'b0;
    end else begin
      if (ctrl_wr)                ctrl_q  <= ctrl_nxt;
      if (wr && sel_ctrl2)        ctrl2_q <= wdata_i;
      if (rd)                     rdata_q <= rd_val;
      pulse_err_q <= |perr;
    end
  end

  assign rdata_o     = rdata_q;
  assign pulse_err_o = pulse_err_q;

  // R9: strobe only after a control write
  a_r9_err_after_ctrl_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_err_o |-> $past(ctrl_wr));

  // R2: illegal read yields zero
  a_r2_illegal_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !legal) |=> (rdata_o == '0));

  // R2: illegal write leaves control words alone
  a_r2_illegal_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !legal) |=> ($stable(ctrl_q) && $stable(ctrl2_q)));
endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;
  logic        perr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] ctl;
  logic [31:0] m_cnt [8];
  logic [31:0] m_rld [8];
  logic [31:0] m_ma  [8];
  logic [31:0] m_mb  [8];
  logic [7:0]  m_irq;
  logic [31:0] got;

  always #5 clk = ~clk;

  tmr_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_tick_i(ext_tick),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .pulse_err_o(perr)
  );

  function automatic logic [7:0] ch_addr(int ch, int w);
    int b = (ch < 3) ? ch : ch + 1;
    return 8'(b * 16 + w * 4);
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic set_ctl(logic [31:0] v);
    for (int c = 0; c < 8; c++)
      if (ctl[4*c] && !v[4*c]) m_cnt[c] = m_rld[c];
    wr(8'h30, v);
    ctl = v;
    for (int c = 0; c < 4; c++) ctl[4*c+3] = 1'b0;
  endtask

  // one external tick: model all enabled external-clock channels
  task automatic ext_pulse();
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (ctl[4*c] && ctl[4*c+1]) begin
        if (m_cnt[c] == 1) begin
          m_cnt[c] = 0;
          if (ctl[4*c+2] || m_ma[c] == 0 || m_mb[c] == 0) m_irq[c] = ~m_irq[c];
        end else if (m_cnt[c] == 0) m_cnt[c] = m_rld[c];
        else m_cnt[c] = m_cnt[c] - 1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ctl = '0; m_irq = '0;
    for (int c = 0; c < 8; c++) begin
      m_cnt[c] = '0; m_rld[c] = '0; m_ma[c] = '0; m_mb[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 irq", {24'h0, irq}, 32'h0);
    check("R10 perr", {31'h0, perr}, 32'h0);
    rd(8'h30, got); check("R10 ctrl", got, 32'h0);
    rd(8'h34, got); check("R10 ctrl2", got, 32'h0);
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 4; w++) begin
        rd(ch_addr(c, w), got); check("R10 chan word", got, 32'h0);
      end

    // R1 / R6: map and read-back; reload write on idle channel loads count
    for (int c = 0; c < 8; c++) begin
      m_rld[c] = 32'h1000_0000 + 32'(c * 32'h0101);
      m_ma[c]  = 32'hA000_0000 + 32'(c);
      m_mb[c]  = 32'hB000_0000 + 32'(c);
      m_cnt[c] = m_rld[c];
      wr(ch_addr(c, 1), m_rld[c]);
      wr(ch_addr(c, 2), m_ma[c]);
      wr(ch_addr(c, 3), m_mb[c]);
    end
    for (int c = 0; c < 8; c++) begin
      rd(ch_addr(c, 0), got); check("R6 reload loads idle count", got, m_rld[c]);
      rd(ch_addr(c, 1), got); check("R1 reload", got, m_rld[c]);
      rd(ch_addr(c, 2), got); check("R1 match A", got, m_ma[c]);
      rd(ch_addr(c, 3), got); check("R1 match B", got, m_mb[c]);
    end

    // R2: illegal and misaligned accesses
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h90, 32'hFFFF_FFFF);
    wr(8'hF4, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h38, got); check("R2 read 0x38", got, 32'h0);
    rd(8'h3C, got); check("R2 read 0x3C", got, 32'h0);
    rd(8'h90, got); check("R2 read 0x90", got, 32'h0);
    rd(8'h05, got); check("R2 misaligned read", got, 32'h0);
    rd(8'h04, got); check("R2 ch0 reload intact", got, m_rld[0]);
    rd(8'h30, got); check("R2 ctrl intact", got, 32'h0);
    rd(8'h34, got); check("R2 ctrl2 intact", got, 32'h0);
    check("R2 irq quiet", {24'h0, irq}, 32'h0);

    // R12: secondary control word
    wr(8'h34, 32'hDEAD_BEEF);
    rd(8'h34, got); check("R12 ctrl2 readback", got, 32'hDEAD_BEEF);
    rd(ch_addr(4, 0), got); check("R12 no effect on count", got, m_cnt[4]);

    // R3/R4/R5: external-tick sweep, reload = c+2
    for (int c = 0; c < 8; c++) begin
      m_rld[c] = 32'(c + 2); m_cnt[c] = m_rld[c];
      m_ma[c] = (c == 1) ? 32'h0 : 32'h7;
      m_mb[c] = 32'h9;
      wr(ch_addr(c, 1), m_rld[c]);
      wr(ch_addr(c, 2), m_ma[c]);
      wr(ch_addr(c, 3), m_mb[c]);
    end
    begin
      logic [31:0] v = '0;
      for (int c = 0; c < 8; c++) v[4*c +: 4] = 4'(3 | (((c % 2) == 0) ? 4 : 0));
      set_ctl(v);
    end
    repeat (5) @(negedge clk);
    rd(ch_addr(5, 0), got); check("R3 no tick, no count", got, m_cnt[5]);
    for (int t = 0; t < 30; t++) begin
      ext_pulse();
      check("R5 irq levels", {24'h0, irq}, {24'h0, m_irq});
    end
    for (int c = 0; c < 8; c++) begin
      rd(ch_addr(c, 0), got); check("R4 count after sweep", got, m_cnt[c]);
    end
    check("R5 ch3 never toggles", {31'h0, irq[3]}, 32'h0);

    // R7: disable reloads, keeps level
    set_ctl(ctl & ~32'h0000_000F);
    rd(ch_addr(0, 0), got); check("R7 disable reloads", got, m_rld[0]);
    check("R7 irq kept", {31'h0, irq[0]}, {31'h0, m_irq[0]});

    // R6: count write ignored when disabled, no counting
    wr(ch_addr(0, 0), 32'h55);
    ext_pulse();
    rd(ch_addr(0, 0), got); check("R6 idle count frozen", got, m_rld[0]);

    // R11: count write on enabled channel
    wr(ch_addr(2, 0), 32'h1234); m_cnt[2] = 32'h1234;
    rd(ch_addr(2, 0), got); check("R11 count write", got, 32'h1234);
    ext_pulse();
    rd(ch_addr(2, 0), got); check("R11 decrement after write", got, 32'h1233);

    // R3: bus-clock counting on ch0
    wr(ch_addr(0, 1), 32'd10); m_rld[0] = 32'd10; m_cnt[0] = 32'd10;
    set_ctl((ctl & ~32'hF) | 32'h1);
    rd(ch_addr(0, 0), got); check("R3 bus clock first", got, 32'd10);
    rd(ch_addr(0, 0), got); check("R3 bus clock next", got, 32'd9);

    // R8: disable + source change together, then enable + ext together
    set_ctl((ctl & ~32'hF) | 32'h2);
    rd(ch_addr(0, 0), got); check("R8 disable reload", got, 32'd10);
    set_ctl(ctl & ~32'h0F00_0000);
    set_ctl(ctl | 32'h0300_0000);
    repeat (4) @(negedge clk);
    rd(ch_addr(6, 0), got); check("R8 enable with ext holds", got, m_rld[6]);

    // R9: pulse bits
    set_ctl(ctl | 32'h0000_0080);
    check("R9 err strobe", {31'h0, perr}, 32'h1);
    @(negedge clk);
    check("R9 strobe one cycle", {31'h0, perr}, 32'h0);
    rd(8'h30, got); check("R9 low pulse bit reads 0", {31'h0, got[7]}, 32'h0);
    set_ctl(ctl | 32'h0080_0000);
    check("R9 no err high chan", {31'h0, perr}, 32'h0);
    rd(8'h30, got); check("R9 high pulse bit kept", got, ctl);

    check("R5 final irq", {24'h0, irq}, {24'h0, m_irq});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule